// File: doc/BRIEF.md
# SDRAM Bank Timing Legality Tracker

This block watches the command stream a memory controller sends to a four-bank SDRAM and decides, on every cycle, whether the command it sees may legally be issued now. It keeps one small state machine per bank. Each machine knows whether its bank is closed, holds an open row, is waiting for a burst to end before precharging by itself, or is precharging. It also counts down the activate-to-access, activate-to-precharge and precharge-to-activate minimums in whole clock cycles.

The three minimums are static configuration inputs. A legal command updates only the bank it addresses. An illegal command is reported with its bank number and changes nothing. Each bank keeps its own delays, so a command to one bank is judged only against that bank's timers.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Commands are encoded on `cmd_op` as 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 read with auto-precharge, 6 write with auto-precharge; code 7 is treated as no command. Each command (codes 1 to 6 with `cmd_valid` high) gets exactly one response on the next cycle, with `rsp_valid` high, `rsp_bank` equal to the addressed bank, `rsp_legal` giving the verdict and `rsp_err` its inverse. No-command cycles give no response.
- R2: An activate is legal only on a closed bank. When accepted, it sets that bank's `bank_open` bit and shows its row on that bank's slice of `open_row`, bits [b*13 +: 13]. An activate to a bank with an open row is illegal.
- R3: A read or write, with or without auto-precharge, is legal only on a bank with an open row, and only when at least max(`cfg_trcd`, 1) cycles have passed since that bank's activate.
- R4: An explicit precharge is legal only on a bank with an open row, and only when at least max(`cfg_tras`, 1) cycles have passed since that bank's activate. A precharge to a closed bank is illegal.
- R5: After a precharge issued in cycle p, an activate to that bank is illegal before cycle p + max(`cfg_trp`, 1) and legal from that cycle on.
- R6: A read or write with auto-precharge in cycle t closes the row at once (`bank_open` falls). The internal precharge takes effect in cycle p = max(t + BURST_LEN, a + max(`cfg_tras`, 1)), where a is the activate cycle. The bank then accepts an activate from p + max(`cfg_trp`, 1). Until then, every command to that bank is illegal.
- R7: An illegal command changes neither `bank_open` nor `open_row`.
- R8: Timing limits are kept per bank. A command to one bank is judged only by that bank's state, so other banks may be activated or accessed during its delays.
- R9: While `rst` is high, no response is produced and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trcd | input | 4 | Activate-to-access minimum, cycles |
| cfg_tras | input | 4 | Activate-to-precharge minimum, cycles |
| cfg_trp | input | 4 | Precharge-to-activate minimum, cycles |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_bank | input | 2 | Addressed bank |
| cmd_row | input | 13 | Row address, used by activate |
| rsp_valid | output | 1 | Verdict for last cycle's command |
| rsp_legal | output | 1 | That command was legal |
| rsp_err | output | 1 | That command was illegal |
| rsp_bank | output | 2 | Bank the verdict refers to |
| bank_open | output | 4 | One bit per bank, row open |
| open_row | output | 52 | Last activated row per bank, 13 bits each |

## Verification
The bound checker checks several rules on every cycle. Each command gets a verdict one cycle later, and idle cycles get none. An accepted activate shows its row. An illegal command leaves the open-row state untouched. No access is accepted before its bank's activate-to-access count has elapsed, and no explicit precharge before its activate-to-precharge count. The precharge-to-activate wait, and the point where an auto-precharge actually begins, depend on burst length and on which of two limits expires later. Only the bench's timed scenarios show these: they hit each limit one cycle early and exactly on time, and they interleave banks so that the independence of the banks is visible.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_RDA  = 3'd5,
    OP_WRA  = 3'd6,
    OP_RSV  = 3'd7
  } sbt_op_e;

  typedef enum logic [1:0] {
    BK_CLOSED = 2'd0,
    BK_OPEN   = 2'd1,
    BK_APEND  = 2'd2,
    BK_PCHG   = 2'd3
  } sbt_bank_st_e;

  function automatic logic is_access(input sbt_op_e op);
    return (op == OP_RD) || (op == OP_WR) || (op == OP_RDA) || (op == OP_WRA);
  endfunction

endpackage

// File: rtl/sbt_bank.sv
module sbt_bank
  import sbt_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int TW        = 4,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_tras,
  input  logic [TW-1:0]    cfg_trp,
  input  logic             sel,
  input  logic [2:0]       op,
  input  logic [ROW_W-1:0] row,
  output logic             legal,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);

  localparam int BCW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  sbt_bank_st_e   st;
  sbt_op_e        opc;
  logic [TW-1:0]  rcd_left;
  logic [TW-1:0]  ras_left;
  logic [TW-1:0]  rp_left;
  logic [BCW-1:0] bst_left;
  logic           act_ready;
  logic           go;

  // Counter value loaded at the command edge: a limit of N makes the
  // dependent command legal N cycles later (at least one).
  function automatic logic [TW-1:0] first_left(input logic [TW-1:0] lim);
    return (lim == '0) ? '0 : lim - 1'b1;
  endfunction

  assign opc       = sbt_op_e'(op);
  assign act_ready = (st == BK_CLOSED) || ((st == BK_PCHG) && (rp_left == '0));

  always_comb begin
    legal = 1'b1;
    if (opc == OP_ACT) begin
      legal = act_ready;
    end else if (is_access(opc)) begin
      legal = (st == BK_OPEN) && (rcd_left == '0);
    end else if (opc == OP_PRE) begin
      legal = (st == BK_OPEN) && (ras_left == '0);
    end
  end

  assign go      = sel && legal;
  assign is_open = (st == BK_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BK_CLOSED;
      rcd_left <= '0;
      ras_left <= '0;
      rp_left  <= '0;
      bst_left <= '0;
      row_q    <= '0;
    end else begin
      if (rcd_left != '0) rcd_left <= rcd_left - 1'b1;
      if (ras_left != '0) ras_left <= ras_left - 1'b1;
      if (rp_left  != '0) rp_left  <= rp_left  - 1'b1;
      if (bst_left != '0) bst_left <= bst_left - 1'b1;
      unique case (st)
        BK_CLOSED: begin
          if (go && opc == OP_ACT) begin
            st       <= BK_OPEN;
            row_q    <= row;
            rcd_left <= first_left(cfg_trcd);
            ras_left <= first_left(cfg_tras);
          end
        end
        BK_OPEN: begin
          if (go && opc == OP_PRE) begin
            st      <= BK_PCHG;
            rp_left <= first_left(cfg_trp);
          end else if (go && (opc == OP_RDA || opc == OP_WRA)) begin
            st       <= BK_APEND;
            bst_left <= BCW'(BURST_LEN - 1);
          end
        end
        BK_APEND: begin
          if (bst_left == '0 && ras_left == '0) begin
            st      <= BK_PCHG;
            rp_left <= first_left(cfg_trp);
          end
        end
        BK_PCHG: begin
          if (go && opc == OP_ACT) begin
            st       <= BK_OPEN;
            row_q    <= row;
            rcd_left <= first_left(cfg_trcd);
            ras_left <= first_left(cfg_tras);
          end else if (rp_left == '0) begin
            st <= BK_CLOSED;
          end
        end
        default: st <= BK_CLOSED;
      endcase
    end
  end

endmodule

// File: rtl/sbt_decode.sv
module sbt_decode
  import sbt_pkg::*;
#(
  parameter int NB = 4,
  localparam int BA_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [BA_W-1:0] cmd_bank,
  input  logic [NB-1:0]   bank_legal,
  output logic [NB-1:0]   bank_sel,
  output logic            cmd_go,
  output logic            cmd_ok
);

  sbt_op_e opc;
  assign opc    = sbt_op_e'(cmd_op);
  assign cmd_go = cmd_valid && (opc != OP_NONE) && (opc != OP_RSV);
  assign cmd_ok = bank_legal[cmd_bank];

  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign bank_sel[b] = cmd_go && (cmd_bank == BA_W'(b));
  end

endmodule

// File: rtl/sbt_resp.sv
module sbt_resp #(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_go,
  input  logic            cmd_ok,
  input  logic [BA_W-1:0] cmd_bank,
  output logic            rsp_valid,
  output logic            rsp_legal,
  output logic            rsp_err,
  output logic [BA_W-1:0] rsp_bank
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_legal <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_bank  <= '0;
    end else begin
      rsp_valid <= cmd_go;
      rsp_legal <= cmd_go && cmd_ok;
      rsp_err   <= cmd_go && !cmd_ok;
      rsp_bank  <= cmd_go ? cmd_bank : '0;
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NB        = 4,
  parameter int ROW_W     = 13,
  parameter int TW        = 4,
  parameter int BURST_LEN = 4,
  localparam int BA_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TW-1:0]       cfg_trcd,
  input  logic [TW-1:0]       cfg_tras,
  input  logic [TW-1:0]       cfg_trp,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [BA_W-1:0]     cmd_bank,
  input  logic [ROW_W-1:0]    cmd_row,
  output logic                rsp_valid,
  output logic                rsp_legal,
  output logic                rsp_err,
  output logic [BA_W-1:0]     rsp_bank,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] open_row
);

  logic [NB-1:0] bank_sel;
  logic [NB-1:0] bank_legal;
  logic          cmd_go;
  logic          cmd_ok;

  sbt_decode #(.NB(NB)) u_dec (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .bank_legal (bank_legal),
    .bank_sel   (bank_sel),
    .cmd_go     (cmd_go),
    .cmd_ok     (cmd_ok)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sbt_bank #(.ROW_W(ROW_W), .TW(TW), .BURST_LEN(BURST_LEN)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .cfg_trcd (cfg_trcd),
      .cfg_tras (cfg_tras),
      .cfg_trp  (cfg_trp),
      .sel      (bank_sel[b]),
      .op       (cmd_op),
      .row      (cmd_row),
      .legal    (bank_legal[b]),
      .is_open  (bank_open[b]),
      .row_q    (open_row[b*ROW_W +: ROW_W])
    );
  end

  sbt_resp #(.BA_W(BA_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .cmd_go    (cmd_go),
    .cmd_ok    (cmd_ok),
    .cmd_bank  (cmd_bank),
    .rsp_valid (rsp_valid),
    .rsp_legal (rsp_legal),
    .rsp_err   (rsp_err),
    .rsp_bank  (rsp_bank)
  );

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker
  import sbt_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  parameter int TW    = 4,
  localparam int BA_W = (NB > 1) ? $clog2(NB) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic [TW-1:0]       cfg_trcd,
  input logic [TW-1:0]       cfg_tras,
  input logic [2:0]          cmd_op,
  input logic [BA_W-1:0]     cmd_bank,
  input logic [ROW_W-1:0]    cmd_row,
  input logic                cmd_go,
  input logic                cmd_ok,
  input logic                rsp_valid,
  input logic                rsp_legal,
  input logic [BA_W-1:0]     rsp_bank,
  input logic [NB-1:0]       bank_open,
  input logic [NB*ROW_W-1:0] open_row
);

  sbt_op_e          opc;
  logic [BA_W-1:0]  prev_bank;
  logic [ROW_W-1:0] prev_row;
  logic [ROW_W-1:0] row_of_prev;
  logic [TW-1:0]    since_act [NB];

  assign opc         = sbt_op_e'(cmd_op);
  assign row_of_prev = open_row[prev_bank*ROW_W +: ROW_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bank <= '0;
      prev_row  <= '0;
    end else begin
      prev_bank <= cmd_bank;
      prev_row  <= cmd_row;
    end
  end

  // R1: one verdict per command, one cycle later
  p_verdict_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> rsp_valid && (rsp_legal == $past(cmd_ok)) && (rsp_bank == $past(cmd_bank)));

  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !cmd_go |=> !rsp_valid);

  // R2: accepted activate exposes its row
  p_act_row_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_ok && opc == OP_ACT) |=> bank_open[prev_bank] && (row_of_prev == prev_row));

  // R7: rejected command leaves state alone
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && !cmd_ok) |=> $stable(bank_open) && $stable(open_row));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    always_ff @(posedge clk) begin
      if (rst) begin
        since_act[b] <= '0;
      end else if (cmd_go && cmd_ok && opc == OP_ACT && cmd_bank == BA_W'(b)) begin
        since_act[b] <= TW'(1);
      end else if (since_act[b] != '1 && since_act[b] != '0) begin
        since_act[b] <= since_act[b] + 1'b1;
      end
    end

    // R3: no access before activate-to-access count
    p_trcd_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd_go && cmd_ok && is_access(opc) && cmd_bank == BA_W'(b))
        |-> (since_act[b] != '0) && (since_act[b] >= cfg_trcd));

    // R4: no precharge before activate-to-precharge count
    p_tras_r4: assert property (@(posedge clk) disable iff (rst)
      (cmd_go && cmd_ok && opc == OP_PRE && cmd_bank == BA_W'(b))
        |-> (since_act[b] != '0) && (since_act[b] >= cfg_tras));
  end

endmodule

bind sdram_bank_tracker sbt_checker #(.NB(NB), .ROW_W(ROW_W), .TW(TW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_trcd  (cfg_trcd),
  .cfg_tras  (cfg_tras),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank),
  .cmd_row   (cmd_row),
  .cmd_go    (cmd_go),
  .cmd_ok    (cmd_ok),
  .rsp_valid (rsp_valid),
  .rsp_legal (rsp_legal),
  .rsp_bank  (rsp_bank),
  .bank_open (bank_open),
  .open_row  (open_row)
);

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;

  typedef struct {
    logic       legal;
    logic [1:0] bank;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_trcd = 4'd3;
  logic [3:0]  cfg_tras = 4'd9;
  logic [3:0]  cfg_trp  = 4'd2;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [1:0]  cmd_bank = 2'd0;
  logic [12:0] cmd_row = 13'd0;
  logic        rsp_valid, rsp_legal, rsp_err;
  logic [1:0]  rsp_bank;
  logic [3:0]  bank_open;
  logic [51:0] open_row;

  int   vectors = 0;
  int   fails = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  sdram_bank_tracker u0 (
    .clk(clk), .rst(rst),
    .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .rsp_valid(rsp_valid), .rsp_legal(rsp_legal), .rsp_err(rsp_err), .rsp_bank(rsp_bank),
    .bank_open(bank_open), .open_row(open_row)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: one command per cycle, expected verdict pushed to the scoreboard
  task automatic issue(input logic [2:0] op, input int bank, input logic [12:0] row,
                       input logic exp_legal, input string tag);
    exp_t e;
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_bank  = bank[1:0];
    cmd_row   = row;
    if (op != 3'd0 && op != 3'd7) begin
      e.legal = exp_legal;
      e.bank  = bank[1:0];
      e.tag   = tag;
      q.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected verdicts as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid && !done) begin
      if (q.size() == 0) begin
        vectors++;
        fails++;
        $display("FAIL R1: unexpected response got bank %0d expected none", rsp_bank);
      end else begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (rsp_legal !== e.legal || rsp_err !== !e.legal || rsp_bank !== e.bank) begin
          fails++;
          $display("FAIL %s: got legal=%0b err=%0b bank=%0d expected legal=%0b err=%0b bank=%0d",
                   e.tag, rsp_legal, rsp_err, rsp_bank, e.legal, !e.legal, e.bank);
        end
      end
    end
  end

  function automatic logic [12:0] row_of(input int b);
    return open_row[b*13 +: 13];
  endfunction

  initial begin
    // R9: reset holds everything quiet even with a command present
    cmd_valid = 1'b1;
    cmd_op    = 3'd1;
    repeat (3) @(negedge clk);
    check("R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R9 bank_open in reset", 32'(bank_open), 32'd0);
    rst = 1'b0;

    issue(3'd1, 0, 13'h0123, 1'b1, "R2 act b0");                  // c0
    check("R2 open bit b0", 32'(bank_open), 32'h1);
    check("R2 row b0", 32'(row_of(0)), 32'h0123);
    issue(3'd2, 0, 13'h0, 1'b0, "R3 rd one cycle after act");      // c1
    check("R7 open after bad read", 32'(bank_open), 32'h1);
    issue(3'd1, 1, 13'h0055, 1'b1, "R8 act b1 during b0 delay");   // c2
    issue(3'd2, 0, 13'h0, 1'b1, "R3 rd exactly at trcd");          // c3
    issue(3'd4, 0, 13'h0, 1'b0, "R4 pre before tras");             // c4
    idle(4);                                                       // c5-c8
    issue(3'd4, 0, 13'h0, 1'b1, "R4 pre exactly at tras");         // c9
    check("R4 b0 closed", 32'(bank_open[0]), 32'd0);
    issue(3'd1, 0, 13'h00AB, 1'b0, "R5 act one cycle early");      // c10
    check("R7 row kept after bad act", 32'(row_of(0)), 32'h0123);
    issue(3'd1, 0, 13'h00AB, 1'b1, "R5 act exactly at trp");       // c11
    check("R2 new row b0", 32'(row_of(0)), 32'h00AB);
    issue(3'd6, 1, 13'h0, 1'b1, "R6 write auto-pre b1");           // c12
    check("R6 b1 closed at once", 32'(bank_open), 32'h1);
    issue(3'd2, 1, 13'h0, 1'b0, "R6 rd during auto-pre");          // c13
    issue(3'd4, 1, 13'h0, 1'b0, "R6 pre during auto-pre");         // c14
    idle(2);                                                       // c15-c16
    issue(3'd1, 1, 13'h1FFF, 1'b0, "R6 act before burst+trp");     // c17
    issue(3'd1, 1, 13'h1FFF, 1'b1, "R6 act at burst+trp");         // c18
    check("R2 row b1", 32'(row_of(1)), 32'h1FFF);
    issue(3'd1, 2, 13'h00F0, 1'b1, "R8 act b2");                   // c19
    idle(2);                                                       // c20-c21
    issue(3'd5, 2, 13'h0, 1'b1, "R3 rda b2 at trcd");              // c22
    idle(6);                                                       // c23-c28
    issue(3'd1, 2, 13'h00F1, 1'b0, "R6 act before tras+trp");      // c29
    issue(3'd1, 2, 13'h00F1, 1'b1, "R6 act at tras+trp");          // c30
    issue(3'd3, 3, 13'h0, 1'b0, "R3 wr to closed b3");             // c31
    issue(3'd4, 3, 13'h0, 1'b0, "R4 pre to closed b3");            // c32
    issue(3'd1, 0, 13'h0777, 1'b0, "R2 act on open b0");           // c33
    check("R7 row b0 after bad act", 32'(row_of(0)), 32'h00AB);
    check("R7 open bits", 32'(bank_open), 32'h7);
    issue(3'd7, 0, 13'h0, 1'b0, "R1 reserved code");               // c34
    issue(3'd3, 0, 13'h0, 1'b1, "R3 wr b0 long after act");        // c35
    idle(3);
    check("R1 all verdicts seen", 32'(q.size()), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule